// File: doc/BRIEF.md
# Zero-Wait Write, One-Wait Read Bus Slave Controller

This block sits on an AHB-style system bus as a slave and fronts a small register store. It watches the slave select, the bus-ready input, the write flag and the transfer type during each address phase, and drives the ready-out and the two-bit response back to the bus. Writes finish in a single data-phase cycle. Reads always take two data-phase cycles: a cycle with ready low, in which the store is read into a holding register, and then a completing cycle that presents the read data with ready high.

The address and direction are captured when a transfer is accepted, and they are used in the data phase that follows. This lets a new transfer's address phase overlap the data phase of the transfer before it. Transfers of type IDLE or BUSY, unselected cycles, and cycles with bus-ready low leave the controller idle. The response is always OKAY, because there are no error, split or retry paths.

Top module: `ahbw_slave_ctrl`

## Requirements
- R1: After reset, ready-out is 1, the response is OKAY (2'b00), read data is zero and every register in the store reads back as zero.
- R2: An address phase is ignored when the slave select is 0, when bus-ready-in is 0, or when the transfer type is IDLE (2'b00) or BUSY (2'b01). In that case ready-out stays 1 in the next cycle and the store is not written.
- R3: A transfer of type NONSEQ (2'b10) or SEQ (2'b11) with select=1, bus-ready-in=1 and write flag 1 has a data phase of exactly one cycle with ready-out 1. The write data present in that cycle is stored at the word index that was given in the address phase.
- R4: The same transfer with write flag 0 has a data phase of exactly two cycles. Ready-out is 0 in the first cycle and 1 in the second.
- R5: The response output is OKAY (2'b00) in every cycle.
- R6: In the completing cycle of a read, read data equals the store content at the word index captured in the address phase. This includes a value written by a write whose data phase ended just before that read's wait cycle.
- R7: A new address phase presented during the final data-phase cycle of a write or a read is accepted, so transfers can run back to back with no idle cycle between them.
- R8: Bus inputs seen during the read wait cycle have no effect. The read still completes in the next cycle, and a write presented in the wait cycle is not performed.
- R9: Read data is zero in every cycle other than the completing cycle of a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| hsel | input | 1 | Slave select |
| hready_in | input | 1 | Bus-wide ready, marks a valid address phase |
| hwrite | input | 1 | 1 = write, 0 = read |
| htrans | input | 2 | Transfer type: 00 IDLE, 01 BUSY, 10 NONSEQ, 11 SEQ |
| haddr | input | IDX_W | Word index into the register store |
| hwdata | input | DATA_W | Write data, valid in the write data phase |
| hready_out | output | 1 | Slave ready, low during the read wait cycle |
| hresp | output | 2 | Transfer response, always OKAY |
| hrdata | output | DATA_W | Read data, valid in the read completing cycle |

## Verification
The assertions assume the master follows the bus rule that an address phase counts only while bus-ready-in is high. In the single-slave bench, bus-ready-in is driven high in every address phase, including a phase that overlaps the read wait cycle. That phase is exactly what R8 requires the slave to ignore. The bench keeps the transfer type to the four legal codes and never changes inputs near a clock edge, so each property sees clean address phases. Back-to-back pairs, read-after-write to the same word and a write issued during a wait cycle are the patterns the properties must hold across.

// File: rtl/ahbw_pkg.sv
package ahbw_pkg;

    localparam logic [1:0] HT_IDLE   = 2'b00;
    localparam logic [1:0] HT_BUSY   = 2'b01;
    localparam logic [1:0] HT_NONSEQ = 2'b10;
    localparam logic [1:0] HT_SEQ    = 2'b11;

    localparam logic [1:0] RESP_OKAY = 2'b00;

    // Controller phases: idle, read wait, write data phase, read completion
    typedef enum logic [1:0] {
        PH_IDLE    = 2'b00,
        PH_RD_WAIT = 2'b01,
        PH_WR_DATA = 2'b10,
        PH_RD_DATA = 2'b11
    } phase_e;

endpackage

// File: rtl/ahbw_req_decode.sv
module ahbw_req_decode (
    input  logic       hsel,
    input  logic       hready_in,
    input  logic       hwrite,
    input  logic [1:0] htrans,
    output logic       req_wr,
    output logic       req_rd
);
    import ahbw_pkg::*;

    logic active;

    always_comb begin
        // Only NONSEQ and SEQ carry data; IDLE and BUSY are ignored
        active = hsel && hready_in && ((htrans == HT_NONSEQ) || (htrans == HT_SEQ));
        req_wr = active && hwrite;
        req_rd = active && !hwrite;
    end

endmodule

// File: rtl/ahbw_fsm.sv
module ahbw_fsm #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_wr,
    input  logic              req_rd,
    input  logic [IDX_W-1:0]  addr_idx,
    input  logic [DATA_W-1:0] store_rdata,
    output logic [IDX_W-1:0]  store_idx,
    output logic              store_wr,
    output logic              hready_out,
    output logic [1:0]        hresp,
    output logic [DATA_W-1:0] hrdata
);
    import ahbw_pkg::*;

    typedef struct packed {
        phase_e            phase;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W-1:0] rdata;
    } fsm_t;

    fsm_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_RD_WAIT: begin
                // Bus inputs are held by the master here; the slave ignores them
                st_d.phase = PH_RD_DATA;
                st_d.rdata = store_rdata;
            end
            default: begin
                if (req_wr) begin
                    st_d.phase = PH_WR_DATA;
                    st_d.idx   = addr_idx;
                end else if (req_rd) begin
                    st_d.phase = PH_RD_WAIT;
                    st_d.idx   = addr_idx;
                end else begin
                    st_d.phase = PH_IDLE;
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{phase: PH_IDLE, idx: '0, rdata: '0};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        store_idx  = st_q.idx;
        store_wr   = (st_q.phase == PH_WR_DATA);
        hready_out = (st_q.phase != PH_RD_WAIT);
        hresp      = RESP_OKAY;
        hrdata     = (st_q.phase == PH_RD_DATA) ? st_q.rdata : '0;
    end

endmodule

// File: rtl/ahbw_regstore.sv
module ahbw_regstore #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    localparam int NUM_REGS = 1 << IDX_W;

    logic [DATA_W-1:0] word_q [NUM_REGS];

    for (genvar g = 0; g < NUM_REGS; g++) begin : g_word
        logic [DATA_W-1:0] word_d;

        always_comb begin
            word_d = word_q[g];
            if (wr_en && (idx == IDX_W'(g))) begin
                word_d = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q[g] <= '0;
            end else begin
                word_q[g] <= word_d;
            end
        end
    end

    always_comb begin
        rdata = word_q[idx];
    end

endmodule

// File: rtl/ahbw_slave_ctrl.sv
module ahbw_slave_ctrl #(
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              hsel,
    input  logic              hready_in,
    input  logic              hwrite,
    input  logic [1:0]        htrans,
    input  logic [IDX_W-1:0]  haddr,
    input  logic [DATA_W-1:0] hwdata,
    output logic              hready_out,
    output logic [1:0]        hresp,
    output logic [DATA_W-1:0] hrdata
);
    logic              req_wr;
    logic              req_rd;
    logic [IDX_W-1:0]  store_idx;
    logic              store_wr;
    logic [DATA_W-1:0] store_rdata;

    ahbw_req_decode u_decode (
        .hsel      (hsel),
        .hready_in (hready_in),
        .hwrite    (hwrite),
        .htrans    (htrans),
        .req_wr    (req_wr),
        .req_rd    (req_rd)
    );

    ahbw_fsm #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .req_wr      (req_wr),
        .req_rd      (req_rd),
        .addr_idx    (haddr),
        .store_rdata (store_rdata),
        .store_idx   (store_idx),
        .store_wr    (store_wr),
        .hready_out  (hready_out),
        .hresp       (hresp),
        .hrdata      (hrdata)
    );

    ahbw_regstore #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (store_wr),
        .idx   (store_idx),
        .wdata (hwdata),
        .rdata (store_rdata)
    );

endmodule

// File: rtl/ahbw_slave_ctrl_chk.sv
module ahbw_slave_ctrl_chk #(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              hsel,
    input logic              hready_in,
    input logic              hwrite,
    input logic [1:0]        htrans,
    input logic              hready_out,
    input logic [DATA_W-1:0] hrdata
);
    logic addr_valid;
    assign addr_valid = hsel && hready_in && htrans[1];

    AST_WRITE_NO_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && hwrite && hready_out) |=> hready_out); // R3

    AST_READ_INSERTS_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (addr_valid && !hwrite && hready_out) |=> !hready_out); // R4

    AST_WAIT_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        !hready_out |=> hready_out); // R8

    AST_IGNORED_PHASE_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (!addr_valid && hready_out) |=> hready_out); // R2

    AST_RDATA_ONLY_AFTER_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
        (hrdata != '0) |-> !$past(hready_out)); // R9

endmodule

bind ahbw_slave_ctrl ahbw_slave_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .hsel       (hsel),
    .hready_in  (hready_in),
    .hwrite     (hwrite),
    .htrans     (htrans),
    .hready_out (hready_out),
    .hrdata     (hrdata)
);

// File: tb/ahbw_slave_ctrl_bench.sv
`timescale 1ns/1ps
module ahbw_slave_ctrl_bench;
    localparam int DATA_W = 32;
    localparam int IDX_W  = 3;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              hsel = 1'b0;
    logic              hready_in = 1'b1;
    logic              hwrite = 1'b0;
    logic [1:0]        htrans = 2'b00;
    logic [IDX_W-1:0]  haddr = '0;
    logic [DATA_W-1:0] hwdata = '0;
    logic              hready_out;
    logic [1:0]        hresp;
    logic [DATA_W-1:0] hrdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ahbw_slave_ctrl #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_ahbw_slave_ctrl (
        .clk(clk), .rst_n(rst_n), .hsel(hsel), .hready_in(hready_in),
        .hwrite(hwrite), .htrans(htrans), .haddr(haddr), .hwdata(hwdata),
        .hready_out(hready_out), .hresp(hresp), .hrdata(hrdata)
    );

    task automatic check(input string req, input logic [DATA_W-1:0] act,
                         input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        check("R5 hresp", DATA_W'(hresp), '0);
    endtask

    task automatic bus_idle();
        hsel = 1'b0; hready_in = 1'b1; hwrite = 1'b0; htrans = 2'b00;
    endtask

    task automatic addr_phase(input logic wr, input logic [IDX_W-1:0] a,
                              input logic [1:0] tr);
        hsel = 1'b1; hready_in = 1'b1; hwrite = wr; htrans = tr; haddr = a;
    endtask

    // R3: single data-phase cycle
    task automatic do_write(input logic [IDX_W-1:0] a, input logic [DATA_W-1:0] d);
        addr_phase(1'b1, a, 2'b10);
        step();
        bus_idle();
        hwdata = d;
        check("R3 write data phase ready", DATA_W'(hready_out), 1);
        step();
        hwdata = 32'hDEAD_BEEF;
        check("R3 ready after write", DATA_W'(hready_out), 1);
    endtask

    // R4 wait then completion, R6 data, R9 zero around it
    task automatic do_read(input logic [IDX_W-1:0] a, input logic [DATA_W-1:0] exp);
        addr_phase(1'b0, a, 2'b11);
        step();
        bus_idle();
        check("R4 wait cycle ready low", DATA_W'(hready_out), 0);
        check("R9 rdata zero in wait", hrdata, '0);
        step();
        check("R4 completion ready high", DATA_W'(hready_out), 1);
        check("R6 read data", hrdata, exp);
        step();
        check("R9 rdata zero after read", hrdata, '0);
    endtask

    task automatic test_reset();
        check("R1 ready after reset", DATA_W'(hready_out), 1);
        check("R1 resp after reset", DATA_W'(hresp), '0);
        check("R1 rdata after reset", hrdata, '0);
        for (int i = 0; i < (1 << IDX_W); i++) begin
            do_read(IDX_W'(i), '0);
        end
    endtask

    task automatic test_ignored();
        // unselected, bus not ready, IDLE, BUSY: none writes word 5
        hwdata = 32'h1111_2222;
        addr_phase(1'b1, 3'd5, 2'b10); hsel = 1'b0;
        step(); check("R2 unselected ready", DATA_W'(hready_out), 1);
        addr_phase(1'b1, 3'd5, 2'b10); hready_in = 1'b0;
        step(); check("R2 hready_in low ready", DATA_W'(hready_out), 1);
        addr_phase(1'b1, 3'd5, 2'b00);
        step(); check("R2 IDLE ready", DATA_W'(hready_out), 1);
        addr_phase(1'b0, 3'd5, 2'b01);
        step(); check("R2 BUSY ready", DATA_W'(hready_out), 1);
        bus_idle();
        step();
        do_read(3'd5, '0);
    endtask

    task automatic test_write_read();
        do_write(3'd1, 32'hA5A5_0001);
        do_write(3'd6, 32'h0BAD_F00D);
        do_read(3'd1, 32'hA5A5_0001);
        do_read(3'd6, 32'h0BAD_F00D);
    endtask

    // R7: write then read of the same word with no gap
    task automatic test_back_to_back();
        addr_phase(1'b1, 3'd2, 2'b10);
        step();
        hwdata = 32'h1234_5678;
        addr_phase(1'b0, 3'd2, 2'b11);
        check("R7 write phase ready", DATA_W'(hready_out), 1);
        step();
        bus_idle();
        hwdata = 32'hDEAD_BEEF;
        check("R7 read accepted back to back", DATA_W'(hready_out), 0);
        step();
        check("R6 read-after-write data", hrdata, 32'h1234_5678);
        // read completion overlapped with a new write
        addr_phase(1'b1, 3'd3, 2'b11);
        step();
        bus_idle();
        hwdata = 32'h7777_3333;
        check("R7 write accepted after read", DATA_W'(hready_out), 1);
        check("R9 rdata zero in write phase", hrdata, '0);
        step();
        do_read(3'd3, 32'h7777_3333);
    endtask

    // R8: write presented during the wait cycle is dropped
    task automatic test_wait_ignored();
        addr_phase(1'b0, 3'd1, 2'b10);
        step();
        addr_phase(1'b1, 3'd4, 2'b10);
        hwdata = 32'hFFFF_0000;
        check("R8 in wait", DATA_W'(hready_out), 0);
        step();
        bus_idle();
        check("R8 read completes", DATA_W'(hready_out), 1);
        check("R8 read data", hrdata, 32'hA5A5_0001);
        step();
        check("R8 idle after read", DATA_W'(hready_out), 1);
        do_read(3'd4, '0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_ignored();
        test_write_read();
        test_back_to_back();
        test_wait_ignored();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule